// File: doc/BRIEF.md
# Segment Limit Query Unit

This unit answers a protected-mode processor's request for the byte limit of a segment. Given a 16-bit selector, the current privilege level, an operand size and a long-mode flag, it picks the global or local descriptor table, checks that the 8-byte descriptor lies inside that table, fetches it through a simple read port, and decides whether the descriptor may be queried at this privilege. On success it returns the byte-granular limit, sized to the operand, with a success flag set. On failure it raises the same completion pulse with the flag clear and a zero limit. It never raises a fault.

A query is launched by a one-cycle `start_i` while the unit is idle. Selector problems that can be seen without memory (null selector, descriptor outside the table) complete in the very next cycle without a read. Otherwise the unit issues one read request, holds it until accepted, waits for the response, and pulses `done_o` in the cycle after the response arrives. `start_i` is ignored while `busy_o` is high, and is accepted again in the cycle that carries `done_o`.

Top module: `seglim_query`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_valid_o` are all 0.
- R2: Only `sel_i[15:0]` is used; bits above 15 have no effect on address or result.
- R3: A selector with bits [15:2] all zero is null: `done_o` rises in the cycle after `start_i` with `ok_o`=0, and no read is issued.
- R4: `sel_i[2]`=1 selects the local table, 0 the global table; the read address is table base plus `sel_i[15:3]`*8. When that offset plus 7 exceeds the table limit, the query fails like R3 without a read.
- R5: `mem_req_valid_o` stays high with a stable `mem_addr_o` until `mem_req_ready_i`; `busy_o` is high from the accepted start to the result, and a `start_i` while busy is ignored.
- R6: `done_o` is a one-cycle pulse in the cycle after the edge where `mem_rsp_valid_i` is seen, carrying the query latched at start.
- R7: The raw 20-bit limit is data bits [15:0] with bits [51:48] on top; when the granularity bit 55 is 1 the byte limit is raw shifted left 12 with the low 12 bits all ones, otherwise raw.
- R8: A descriptor with bit 44 set (code or data) is always an acceptable type.
- R9: With bit 44 clear, the type in bits [43:40] is accepted only for 1, 2, 3, 9, 11 when `long_mode_i`=0 and only for 0, 2, 9, 11 when `long_mode_i`=1.
- R10: Unless the descriptor is conforming code (bit 44 set and type bits 43 and 42 both 1), the query fails when `cpl_i` or the selector's RPL (`sel_i[1:0]`) is greater than the DPL in bits [46:45].
- R11: `opsize_i` 0 returns only the low 16 bits of the byte limit; 1, 2 and 3 return the 32-bit byte limit, zero-extended to the output width.
- R12: When `done_o` is high with `ok_o`=0, `limit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a query (ignored while busy) |
| sel_i | input | SEL_IN_W | Selector operand; low 16 bits used |
| cpl_i | input | 2 | Current privilege level |
| opsize_i | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit, 3: as 32-bit |
| long_mode_i | input | 1 | Selects the long-mode system type set |
| gdt_base_i | input | ADDR_W | Global table base address |
| gdt_limit_i | input | TLIM_W | Global table limit in bytes |
| ldt_base_i | input | ADDR_W | Local table base address |
| ldt_limit_i | input | TLIM_W | Local table limit in bytes |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_addr_o | output | ADDR_W | Descriptor address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Descriptor, byte 0 in bits [7:0] |
| busy_o | output | 1 | Query in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success flag, valid with done_o |
| limit_o | output | OUT_W | Sized byte limit, valid with done_o |

## Verification
The completion pulse of one query and the acceptance of the next can fall in the same cycle: the bench chains queries so that each new `start_i` is driven in the cycle where the previous `done_o` is high, both after a memory read and after an immediate selector failure. The bench then requires that the new query's first cycle shows the expected outcome (a fresh pulse for a failing selector, or a request with the new address and no pulse), and that the earlier result was reported intact in its own cycle.

// File: rtl/seglim_pkg.sv
// Package: shared constants for the segment limit query unit.
// Assumes descriptors arrive as 64-bit words with byte 0 in bits [7:0].
package seglim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seglim_state_e;

    localparam logic [1:0] OPS_16 = 2'd0;
    localparam logic [1:0] OPS_32 = 2'd1;
    localparam logic [1:0] OPS_64 = 2'd2;

    localparam int DESC_W = 64;

    // Descriptor field positions
    localparam int F_LIM_LO  = 0;
    localparam int F_TYPE    = 40;
    localparam int F_SYSN    = 44;
    localparam int F_DPL     = 45;
    localparam int F_LIM_HI  = 48;
    localparam int F_GRAN    = 55;

    // Accepted system types, one bit per type code
    localparam logic [15:0] SYS_OK_LEGACY = 16'h0A0E; // 1,2,3,9,11
    localparam logic [15:0] SYS_OK_LONG   = 16'h0A05; // 0,2,9,11

endpackage

// File: rtl/seglim_sel_check.sv
// Module: selector pre-check.
// Decides from the selector alone whether a read is needed: flags a null
// selector, picks the table by the table-indicator bit, checks the 8-byte
// descriptor fits under the table limit, and forms the read address.
// Assumes TLIM_W <= 31.
module seglim_sel_check #(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16
) (
    input  logic [15:0]       sel_i,
    input  logic [ADDR_W-1:0] gdt_base_i,
    input  logic [TLIM_W-1:0] gdt_limit_i,
    input  logic [ADDR_W-1:0] ldt_base_i,
    input  logic [TLIM_W-1:0] ldt_limit_i,
    output logic              null_o,
    output logic              fits_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int CMP_W = 32;

    logic [15:0]       offset;
    logic [ADDR_W-1:0] base;
    logic [TLIM_W-1:0] tlim;
    logic [CMP_W-1:0]  last_byte;
    logic [CMP_W-1:0]  tlim_ext;

    // Table selection and byte offset of the descriptor
    always_comb begin
        offset    = {sel_i[15:3], 3'b000};
        base      = sel_i[2] ? ldt_base_i  : gdt_base_i;
        tlim      = sel_i[2] ? ldt_limit_i : gdt_limit_i;
        last_byte = CMP_W'(offset) + CMP_W'(7);
        tlim_ext  = CMP_W'(tlim);
    end

    // Null test, bound test and address
    always_comb begin
        null_o = (sel_i[15:2] == 14'd0);
        fits_o = (last_byte <= tlim_ext);
        addr_o = base + ADDR_W'(offset);
    end
endmodule

// File: rtl/seglim_type_check.sv
// Module: descriptor type and privilege qualifier.
// Accepts every code/data descriptor; for system descriptors uses the
// mode-dependent set of accepted types. Enforces CPL/RPL <= DPL except
// for conforming code.
module seglim_type_check
    import seglim_pkg::*;
(
    input  logic [3:0] type_i,
    input  logic       codedata_i,
    input  logic [1:0] dpl_i,
    input  logic [1:0] cpl_i,
    input  logic [1:0] rpl_i,
    input  logic       long_mode_i,
    output logic       allow_o
);
    logic [15:0] sys_mask;
    logic        type_ok;
    logic        conforming;
    logic        priv_ok;

    // Type legality
    always_comb begin
        sys_mask = long_mode_i ? SYS_OK_LONG : SYS_OK_LEGACY;
        type_ok  = codedata_i | sys_mask[type_i];
    end

    // Privilege visibility
    always_comb begin
        conforming = codedata_i & type_i[3] & type_i[2];
        priv_ok    = conforming | ((cpl_i <= dpl_i) & (rpl_i <= dpl_i));
        allow_o    = type_ok & priv_ok;
    end
endmodule

// File: rtl/seglim_limit_fmt.sv
// Module: limit expansion and sizing.
// Expands a 20-bit raw limit to a 32-bit byte limit by granularity,
// truncates to 16 bits for the small operand size, and zero-extends to
// OUT_W. Assumes OUT_W >= 32.
module seglim_limit_fmt
    import seglim_pkg::*;
#(
    parameter int OUT_W = 64
) (
    input  logic [19:0]      raw_i,
    input  logic             gran_i,
    input  logic [1:0]       opsize_i,
    output logic [OUT_W-1:0] limit_o
);
    logic [31:0] byte_lim;
    logic [31:0] sized;

    // Page-to-byte expansion and operand sizing
    always_comb begin
        byte_lim = gran_i ? {raw_i, 12'hFFF} : {12'h000, raw_i};
        sized    = (opsize_i == OPS_16) ? {16'h0000, byte_lim[15:0]} : byte_lim;
    end

    generate
        if (OUT_W > 32) begin : g_wide
            assign limit_o = {{(OUT_W-32){1'b0}}, sized};
        end else begin : g_narrow
            assign limit_o = sized[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/seglim_query.sv
// Module: segment limit query unit (top).
// Accepts a query while idle, resolves selector-only failures at once,
// otherwise fetches the descriptor through a valid/ready read port and
// reports a one-cycle done with success flag and sized limit.
// Assumes one outstanding read and exactly one response per request.
module seglim_query
    import seglim_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int TLIM_W   = 16,
    parameter int SEL_IN_W = 32,
    parameter int OUT_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SEL_IN_W-1:0] sel_i,
    input  logic [1:0]          cpl_i,
    input  logic [1:0]          opsize_i,
    input  logic                long_mode_i,
    input  logic [ADDR_W-1:0]   gdt_base_i,
    input  logic [TLIM_W-1:0]   gdt_limit_i,
    input  logic [ADDR_W-1:0]   ldt_base_i,
    input  logic [TLIM_W-1:0]   ldt_limit_i,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic                mem_rsp_valid_i,
    input  logic [DESC_W-1:0]   mem_rsp_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                ok_o,
    output logic [OUT_W-1:0]    limit_o
);
    seglim_state_e     state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        cpl_q;
    logic [1:0]        rpl_q;
    logic [1:0]        ops_q;
    logic              lm_q;
    logic              done_q;
    logic              ok_q;
    logic [OUT_W-1:0]  lim_q;

    logic [15:0]       sel16;
    logic              sel_null;
    logic              sel_fits;
    logic [ADDR_W-1:0] sel_addr;
    logic              allow;
    logic [OUT_W-1:0]  fmt_limit;
    logic              sig_unused;

    assign sel16      = sel_i[15:0];
    assign sig_unused = ^{sel_i[SEL_IN_W-1:16], mem_rsp_data_i[39:16],
                          mem_rsp_data_i[47], mem_rsp_data_i[54:52],
                          mem_rsp_data_i[63:56]};

    seglim_sel_check #(
        .ADDR_W (ADDR_W),
        .TLIM_W (TLIM_W)
    ) u_sel (
        .sel_i       (sel16),
        .gdt_base_i  (gdt_base_i),
        .gdt_limit_i (gdt_limit_i),
        .ldt_base_i  (ldt_base_i),
        .ldt_limit_i (ldt_limit_i),
        .null_o      (sel_null),
        .fits_o      (sel_fits),
        .addr_o      (sel_addr)
    );

    seglim_type_check u_type (
        .type_i      (mem_rsp_data_i[F_TYPE +: 4]),
        .codedata_i  (mem_rsp_data_i[F_SYSN]),
        .dpl_i       (mem_rsp_data_i[F_DPL +: 2]),
        .cpl_i       (cpl_q),
        .rpl_i       (rpl_q),
        .long_mode_i (lm_q),
        .allow_o     (allow)
    );

    seglim_limit_fmt #(
        .OUT_W (OUT_W)
    ) u_fmt (
        .raw_i    ({mem_rsp_data_i[F_LIM_HI +: 4], mem_rsp_data_i[F_LIM_LO +: 16]}),
        .gran_i   (mem_rsp_data_i[F_GRAN]),
        .opsize_i (ops_q),
        .limit_o  (fmt_limit)
    );

    // Query sequencing: accept, request, await response, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cpl_q   <= '0;
            rpl_q   <= '0;
            ops_q   <= OPS_32;
            lm_q    <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            lim_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (sel_null || !sel_fits) begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b0;
                            lim_q  <= '0;
                        end else begin
                            state_q <= ST_REQ;
                            addr_q  <= sel_addr;
                            cpl_q   <= cpl_i;
                            rpl_q   <= sel16[1:0];
                            ops_q   <= opsize_i;
                            lm_q    <= long_mode_i;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready_i) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        ok_q    <= allow;
                        lim_q   <= allow ? fmt_limit : '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive
    always_comb begin
        mem_req_valid_o = (state_q == ST_REQ);
        mem_addr_o      = addr_q;
        busy_o          = (state_q != ST_IDLE);
        done_o          = done_q;
        ok_o            = ok_q;
        limit_o         = lim_q;
    end
endmodule

// File: rtl/seglim_query_chk.sv
// Module: protocol and result checker for seglim_query, bound below.
// Observes ports only.
module seglim_query_chk #(
    parameter int ADDR_W   = 32,
    parameter int SEL_IN_W = 32,
    parameter int OUT_W    = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [SEL_IN_W-1:0] sel_i,
    input logic                mem_req_valid_o,
    input logic                mem_req_ready_i,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic                mem_rsp_valid_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                ok_o,
    input logic [OUT_W-1:0]    limit_o
);
    // R5: request held with stable address until accepted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

    // R5: a result is never reported while a read is pending
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !mem_req_valid_o);

    // R6: done lasts one cycle unless a new query starts
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    // R6: success only follows a read response
    a_r6_ok_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o |-> $past(mem_rsp_valid_i));

    // R3: null selector fails in the next cycle
    a_r3_null_fast: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (sel_i[15:2] == 14'd0) |=> done_o && !ok_o && !mem_req_valid_o);

    // R12: failure carries a zero limit
    a_r12_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !ok_o |-> (limit_o == '0));
endmodule

bind seglim_query seglim_query_chk #(
    .ADDR_W   (ADDR_W),
    .SEL_IN_W (SEL_IN_W),
    .OUT_W    (OUT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .sel_i           (sel_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .ok_o            (ok_o),
    .limit_o         (limit_o)
);

// File: tb/seglim_query_test.sv
// Bench for seglim_query: behavioural expectations per query, checked
// at every clock of each transaction.
module seglim_query_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] sel_i = '0;
    logic [1:0]  cpl_i = '0;
    logic [1:0]  opsize_i = 2'd1;
    logic        long_mode_i = 1'b0;
    logic [31:0] gdt_base_i = 32'h1000_0000;
    logic [15:0] gdt_limit_i = 16'h00FF;
    logic [31:0] ldt_base_i = 32'h2000_0400;
    logic [15:0] ldt_limit_i = 16'h003F;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
    logic        busy_o;
    logic        done_o;
    logic        ok_o;
    logic [63:0] limit_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seglim_query uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .cpl_i(cpl_i), .opsize_i(opsize_i), .long_mode_i(long_mode_i),
        .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
        .ldt_base_i(ldt_base_i), .ldt_limit_i(ldt_limit_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .busy_o(busy_o), .done_o(done_o),
        .ok_o(ok_o), .limit_o(limit_o)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] mkd(input logic [19:0] raw, input bit g,
                                        input bit s, input logic [3:0] t,
                                        input logic [1:0] dpl);
        logic [63:0] d;
        d        = '0;
        d[15:0]  = raw[15:0];
        d[39:16] = 24'hC3A596;
        d[43:40] = t;
        d[44]    = s;
        d[46:45] = dpl;
        d[47]    = 1'b1;
        d[51:48] = raw[19:16];
        d[54:52] = 3'b101;
        d[55]    = g;
        d[63:56] = 8'h7E;
        return d;
    endfunction

    // Expected outcome of a fetched descriptor, from the requirements
    task automatic ref_eval(input logic [63:0] d, input int cpl, input int rpl,
                            input int ops, input bit lm,
                            output bit ok, output logic [63:0] lim);
        int  typ = int'(d[43:40]);
        bit  s   = d[44];
        int  dpl = int'(d[46:45]);
        bit  valid, conf;
        longint raw, bl;
        raw = longint'(d[51:48]) * 65536 + longint'(d[15:0]);
        if (s) valid = 1;
        else if (lm) valid = (typ == 0 || typ == 2 || typ == 9 || typ == 11);
        else valid = (typ == 1 || typ == 2 || typ == 3 || typ == 9 || typ == 11);
        conf = s && (typ >= 12);
        ok = valid && (conf || (cpl <= dpl && rpl <= dpl));
        bl = d[55] ? raw * 4096 + 4095 : raw;
        if (ops == 0) bl = bl % 65536;
        lim = ok ? 64'(bl) : 64'd0;
    endtask

    task automatic idle(input int n, input string r);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            chk({r, " idle done"}, 64'(done_o), 64'd0);
            chk({r, " idle busy"}, 64'(busy_o), 64'd0);
        end
    endtask

    // One query; entered and left at a negative edge
    task automatic q(input logic [31:0] sel, input logic [1:0] cpl,
                     input logic [1:0] ops, input bit lm, input logic [63:0] desc,
                     input int rwait, input int dwait, input bit poke,
                     input string r);
        logic [15:0] s16 = sel[15:0];
        bit          nul = (s16[15:2] == 0);
        logic [31:0] base = s16[2] ? ldt_base_i : gdt_base_i;
        int          tl = s16[2] ? int'(ldt_limit_i) : int'(gdt_limit_i);
        int          off = int'(s16[15:3]) * 8;
        bit          early = nul || (off + 7 > tl);
        logic [31:0] eaddr = base + 32'(off);
        bit          eok;
        logic [63:0] elim;
        ref_eval(desc, int'(cpl), int'(s16[1:0]), int'(ops), lm, eok, elim);

        start_i = 1'b1; sel_i = sel; cpl_i = cpl; opsize_i = ops; long_mode_i = lm;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; sel_i = 32'hFFFF_FFFC; cpl_i = 2'd3; opsize_i = 2'd0;
        long_mode_i = ~lm;
        if (early) begin
            chk({r, " early done"}, 64'(done_o), 64'd1);
            chk({r, " early ok"}, 64'(ok_o), 64'd0);
            chk({r, " early limit"}, limit_o, 64'd0);
            chk({r, " early no read"}, 64'(mem_req_valid_o), 64'd0);
            chk({r, " early busy"}, 64'(busy_o), 64'd0);
            return;
        end
        chk({r, " req valid"}, 64'(mem_req_valid_o), 64'd1);
        chk({r, " addr"}, 64'(mem_addr_o), 64'(eaddr));
        chk({r, " no done at start"}, 64'(done_o), 64'd0);
        for (int i = 0; i < rwait; i++) begin
            if (poke && i == 0) begin
                start_i = 1'b1; sel_i = 32'h0000_0020;
            end
            @(posedge clk); @(negedge clk);
            start_i = 1'b0; sel_i = 32'hFFFF_FFFC;
            chk({r, " R5 req held"}, 64'(mem_req_valid_o), 64'd1);
            chk({r, " R5 addr held"}, 64'(mem_addr_o), 64'(eaddr));
            chk({r, " R5 busy"}, 64'(busy_o), 64'd1);
            chk({r, " R5 no done"}, 64'(done_o), 64'd0);
        end
        mem_req_ready_i = 1'b1;
        @(posedge clk); @(negedge clk);
        mem_req_ready_i = 1'b0;
        chk({r, " R5 req dropped"}, 64'(mem_req_valid_o), 64'd0);
        chk({r, " R5 busy wait"}, 64'(busy_o), 64'd1);
        for (int i = 0; i < dwait; i++) begin
            @(posedge clk); @(negedge clk);
            chk({r, " R6 no early done"}, 64'(done_o), 64'd0);
        end
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = desc;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid_i = 1'b0; mem_rsp_data_i = ~desc;
        chk({r, " R6 done"}, 64'(done_o), 64'd1);
        chk({r, " ok"}, 64'(ok_o), 64'(eok));
        chk({r, " limit"}, limit_o, elim);
        chk({r, " R6 idle at done"}, 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", 64'(busy_o), 64'd0);
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 req", 64'(mem_req_valid_o), 64'd0);
        rst_n = 1'b1;
        idle(2, "R1");

        q(32'h0000_0010, 0, 1, 0, mkd(20'h12345, 0, 1, 4'hA, 0), 1, 1, 0, "R7 R8 byte");
        q(32'h0000_0010, 0, 1, 0, mkd(20'h0ABCD, 1, 1, 4'h2, 0), 0, 0, 0, "R7 page");
        q(32'h0000_0010, 0, 0, 0, mkd(20'h0ABCD, 1, 1, 4'h2, 0), 2, 0, 0, "R11 size16");
        q(32'h0000_0010, 0, 2, 0, mkd(20'hFFFFF, 1, 1, 4'h2, 0), 0, 2, 0, "R11 size64");
        q(32'h0000_0010, 0, 3, 0, mkd(20'h8_0001, 1, 1, 4'h2, 0), 0, 0, 0, "R11 size3");
        q(32'h0000_0003, 0, 1, 0, mkd(20'h1, 0, 1, 4'h2, 3), 0, 0, 0, "R3 null");
        q(32'h0000_0004, 0, 1, 0, mkd(20'h00777, 0, 1, 4'h2, 0), 0, 0, 0, "R4 ldt index0");
        q(32'h0000_0100, 0, 1, 0, mkd(20'h1, 0, 1, 4'h2, 0), 0, 0, 0, "R4 gdt over");
        q(32'h0000_00F8, 0, 1, 0, mkd(20'h00F00, 0, 1, 4'h2, 0), 0, 0, 0, "R4 gdt edge");
        q(32'h0000_003C, 0, 1, 0, mkd(20'h0003C, 0, 1, 4'h2, 0), 0, 0, 0, "R4 ldt edge");
        q(32'h0000_0044, 0, 1, 0, mkd(20'h1, 0, 1, 4'h2, 0), 0, 0, 0, "R4 ldt over");
        q(32'hDEAD_0010, 0, 1, 0, mkd(20'h12345, 0, 1, 4'hA, 0), 0, 0, 0, "R2 upper bits");
        q(32'hFFFF_0001, 0, 1, 0, mkd(20'h1, 0, 1, 4'h2, 3), 0, 0, 0, "R2 R3 upper null");
        idle(2, "R6");

        for (int t = 0; t < 16; t++) begin
            q(32'h0000_0018, 0, 1, 0, mkd(20'h00321, 0, 0, 4'(t), 3), 0, 0, 0, "R9 legacy");
            q(32'h0000_0018, 0, 1, 1, mkd(20'h00321, 0, 0, 4'(t), 3), 0, 0, 0, "R9 long");
        end
        for (int t = 0; t < 16; t++)
            q(32'h0000_0020, 3, 1, 0, mkd(20'h00456, 0, 1, 4'(t), 3), 0, 0, 0, "R8 codedata");

        q(32'h0000_0009, 2, 1, 0, mkd(20'h00100, 0, 1, 4'h2, 1), 0, 0, 0, "R10 R12 cpl high");
        q(32'h0000_000A, 0, 1, 0, mkd(20'h00100, 0, 1, 4'h2, 1), 0, 0, 0, "R10 R12 rpl high");
        q(32'h0000_0009, 1, 1, 0, mkd(20'h00100, 0, 1, 4'h2, 1), 0, 0, 0, "R10 equal");
        q(32'h0000_000B, 3, 1, 0, mkd(20'h00200, 0, 1, 4'hE, 0), 0, 0, 0, "R10 conforming");
        q(32'h0000_000B, 3, 1, 0, mkd(20'h00200, 0, 1, 4'hA, 0), 0, 0, 0, "R10 R12 nonconf code");
        q(32'h0000_000B, 3, 1, 0, mkd(20'h00200, 0, 0, 4'h9, 0), 0, 0, 0, "R10 R12 system");

        q(32'h0000_0028, 0, 1, 0, mkd(20'h00ACE, 1, 1, 4'h2, 0), 3, 1, 1, "R5 ignored start");
        idle(1, "R5");

        q(32'h0000_0030, 0, 1, 0, mkd(20'h00010, 0, 1, 4'h2, 0), 0, 0, 0, "R6 chain a");
        q(32'h0000_0000, 0, 1, 0, mkd(20'h0, 0, 1, 4'h2, 0), 0, 0, 0, "R6 chain b");
        q(32'h0000_0000, 0, 1, 0, mkd(20'h0, 0, 1, 4'h2, 0), 0, 0, 0, "R6 chain c");
        q(32'h0000_0030, 0, 0, 0, mkd(20'h1_2345, 1, 1, 4'h2, 0), 0, 0, 0, "R6 chain d");
        idle(2, "R6 tail");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule